// File: doc/BRIEF.md
# Privilege-Filtered Trace Merger

This block gathers trace records from several independent on-chip producers (a processor, an interconnect monitor, a power controller, a cipher engine, a timer and the like) and merges them into a single valid/ready stream bound for the debug trace port. When a record enters, the block attaches a two-bit owner class to it. That class comes from an elaboration parameter of the port the record arrived on. No register and no merge stage can rewrite it afterwards.

A debugger privilege register holds the clearance of the debugger currently attached. An authentication strobe loads it, and it returns to the public class on reset. A record reaches the output only when this clearance is at least the record's class. A record that fails the check is still taken from its producer, so no producer stalls. It is then discarded, and a saturating discard counter advances. Any debugger can read both the counter and the current clearance. A new clearance never takes effect while a record sits on the output waiting for its handshake. It waits for the next record boundary.

Top module: `trace_priv_agg`

## Requirements
- R1: After reset, out_valid is 0, dbg_level is 0 (public) and drop_count is 0.
- R2: Each source i carries the class SRC_TAGS[2i+1:2i], fixed by parameter. A released record shows that class on out_tag and its payload unchanged on out_data. Records leave in the order they were taken from the sources.
- R3: The class encoding is 0 public, 1 end user, 2 OEM, 3 design house. A record with class T is released only when the clearance L in force satisfies L >= T. No record with T > dbg_level ever shows on the output while out_valid is high.
- R4: A record that fails the check is still taken (its src_ready is high for one cycle) and never appears on the output. drop_count then rises by one and stops at 2^DROP_W-1.
- R5: Arbitration is round-robin. After a grant to source i, the search starts at i+1 and wraps. After reset the search starts at source 0.
- R6: While out_valid is high and out_ready is low, out_data and out_tag stay unchanged and out_valid stays high.
- R7: auth_valid loads auth_level as the new clearance at the first record boundary at or after the strobe. A record boundary is a cycle in which out_valid is low or out_ready is high. The new clearance shows on dbg_level one cycle after that boundary. A record taken in that same boundary cycle is judged against the new clearance. If several strobes arrive while the output is stalled, the last one wins.
- R8: At most one src_ready is high in any cycle. A src_ready is high only when its src_valid is high and the cycle is a record boundary.
- R9: dbg_level always shows the clearance currently used for filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | N_SRC | Per-source record valid |
| src_ready | output | N_SRC | Per-source record taken |
| src_data | input | N_SRC*PAYLOAD_W | Per-source payloads, source i at bits [i*PAYLOAD_W +: PAYLOAD_W] |
| auth_valid | input | 1 | Strobe that loads a new debugger clearance |
| auth_level | input | 2 | Clearance to load |
| out_valid | output | 1 | Released record valid |
| out_ready | input | 1 | Trace port accepts the record |
| out_data | output | PAYLOAD_W | Released payload |
| out_tag | output | 2 | Owner class of the released record |
| dbg_level | output | 2 | Clearance in force |
| drop_count | output | DROP_W | Saturating count of discarded records |

## Verification
The hard case comes when a clearance update and the take of a new record fall on the same boundary cycle. The record must then be judged against the new clearance, not the old one. A related case is a clearance strobe that arrives while the output is stalled: it must wait until the stall ends. The bench provokes both cases. It stalls the output with a high-class record held, pulses a lower clearance during the stall, and then releases the stall, while random strobes keep falling on boundary cycles. A reference model in the bench finds the boundary from the port handshake alone. It queues every record that should pass and counts every record that should be discarded. Each output record is compared with the head of that queue and must carry a class no higher than the clearance the model holds.

// File: rtl/trace_tag_pkg.sv
package trace_tag_pkg;

   typedef logic [1:0] priv_t;

   localparam priv_t PRIV_PUBLIC = 2'd0;
   localparam priv_t PRIV_USER   = 2'd1;
   localparam priv_t PRIV_OEM    = 2'd2;
   localparam priv_t PRIV_DESIGN = 2'd3;

   localparam int TAG_W = 2;

   function automatic logic cleared_for(priv_t tag, priv_t lvl);
      return lvl >= tag;
   endfunction

endpackage

// File: rtl/trace_src_stamp.sv
module trace_src_stamp
   import trace_tag_pkg::*;
#(
   parameter int    PAYLOAD_W = 32,
   parameter priv_t OWNER_TAG = PRIV_PUBLIC
) (
   input  logic                       in_valid,
   input  logic [PAYLOAD_W-1:0]       in_data,
   output logic                       rec_valid,
   output logic [PAYLOAD_W+TAG_W-1:0] rec
);
   // class occupies the top bits; it is a constant and no later stage writes it
   assign rec       = {OWNER_TAG, in_data};
   assign rec_valid = in_valid;
endmodule

// File: rtl/trace_rr_arb.sv
module trace_rr_arb #(
   parameter int N     = 4,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             advance,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] grant_idx,
   output logic             grant_any
);
   if (N == 1) begin : g_single
      assign grant     = req;
      assign grant_idx = '0;
      assign grant_any = req[0];
   end else begin : g_rr
      logic [IDX_W-1:0] last_q;
      logic [IDX_W-1:0] cand;

      always_comb begin
         grant     = '0;
         grant_idx = '0;
         grant_any = 1'b0;
         cand      = '0;
         for (int k = 1; k <= N; k++) begin
            cand = IDX_W'((int'(last_q) + k) % N);
            if (!grant_any && req[cand]) begin
               grant_any   = 1'b1;
               grant[cand] = 1'b1;
               grant_idx   = cand;
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       last_q <= IDX_W'(N - 1);
         else if (advance) last_q <= grant_idx;
      end
   end
endmodule

// File: rtl/trace_priv_gate.sv
module trace_priv_gate
   import trace_tag_pkg::*;
#(
   parameter int PAYLOAD_W = 32,
   parameter int DROP_W    = 8,
   localparam int REC_W    = PAYLOAD_W + TAG_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [REC_W-1:0]     in_rec,
   output logic                 in_take,
   input  logic                 auth_valid,
   input  priv_t                auth_level,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [PAYLOAD_W-1:0] out_data,
   output priv_t                out_tag,
   output priv_t                dbg_level,
   output logic [DROP_W-1:0]    drop_count
);
   localparam logic [DROP_W-1:0] DROP_MAX = '1;

   logic              ov_q;
   logic [REC_W-1:0]  rec_q;
   priv_t             lvl_q, lvl_next, pend_lvl_q;
   logic              pend_q;
   logic [DROP_W-1:0] drop_q;
   logic              boundary, apply, accept, pass;
   priv_t             in_tag;

   assign in_tag   = in_rec[REC_W-1 -: TAG_W];
   assign boundary = !ov_q || out_ready;
   assign apply    = boundary && (auth_valid || pend_q);
   assign lvl_next = apply ? (auth_valid ? auth_level : pend_lvl_q) : lvl_q;
   assign accept   = boundary && in_valid;
   assign pass     = accept && cleared_for(in_tag, lvl_next);
   assign in_take  = boundary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q      <= PRIV_PUBLIC;
         pend_q     <= 1'b0;
         pend_lvl_q <= PRIV_PUBLIC;
      end else begin
         lvl_q <= lvl_next;
         if (apply) begin
            pend_q <= 1'b0;
         end else if (auth_valid) begin
            pend_q     <= 1'b1;
            pend_lvl_q <= auth_level;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q  <= 1'b0;
         rec_q <= '0;
      end else if (boundary) begin
         ov_q <= pass;
         if (pass) rec_q <= in_rec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                drop_q <= '0;
      else if (accept && !pass && drop_q != DROP_MAX) drop_q <= drop_q + 1'b1;
   end

   assign out_valid  = ov_q;
   assign out_data   = rec_q[PAYLOAD_W-1:0];
   assign out_tag    = rec_q[REC_W-1 -: TAG_W];
   assign dbg_level  = lvl_q;
   assign drop_count = drop_q;
endmodule

// File: rtl/trace_priv_agg.sv
module trace_priv_agg
   import trace_tag_pkg::*;
#(
   parameter int                   N_SRC     = 5,
   parameter int                   PAYLOAD_W = 32,
   parameter int                   DROP_W    = 8,
   parameter logic [2*N_SRC-1:0]   SRC_TAGS  = 10'b00_00_01_10_11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_SRC-1:0]           src_valid,
   output logic [N_SRC-1:0]           src_ready,
   input  logic [N_SRC*PAYLOAD_W-1:0] src_data,
   input  logic                       auth_valid,
   input  logic [1:0]                 auth_level,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [PAYLOAD_W-1:0]       out_data,
   output logic [1:0]                 out_tag,
   output logic [1:0]                 dbg_level,
   output logic [DROP_W-1:0]          drop_count
);
   localparam int REC_W = PAYLOAD_W + TAG_W;
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (N_SRC < 1)     $error("trace_priv_agg: N_SRC must be at least 1");
   if (PAYLOAD_W < 1) $error("trace_priv_agg: PAYLOAD_W must be at least 1");
   if (DROP_W < 1)    $error("trace_priv_agg: DROP_W must be at least 1");

   logic [N_SRC-1:0] rec_valid;
   logic [REC_W-1:0] recs [N_SRC];
   logic [N_SRC-1:0] grant;
   logic [IDX_W-1:0] grant_idx;
   logic             grant_any;
   logic             take;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      trace_src_stamp #(
         .PAYLOAD_W (PAYLOAD_W),
         .OWNER_TAG (priv_t'(SRC_TAGS[2*g +: 2]))
      ) u_stamp (
         .in_valid  (src_valid[g]),
         .in_data   (src_data[g*PAYLOAD_W +: PAYLOAD_W]),
         .rec_valid (rec_valid[g]),
         .rec       (recs[g])
      );
   end

   trace_rr_arb #(.N(N_SRC), .IDX_W(IDX_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (rec_valid),
      .advance   (grant_any && take),
      .grant     (grant),
      .grant_idx (grant_idx),
      .grant_any (grant_any)
   );

   trace_priv_gate #(.PAYLOAD_W(PAYLOAD_W), .DROP_W(DROP_W)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (grant_any),
      .in_rec     (recs[grant_idx]),
      .in_take    (take),
      .auth_valid (auth_valid),
      .auth_level (auth_level),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .out_tag    (out_tag),
      .dbg_level  (dbg_level),
      .drop_count (drop_count)
   );

   assign src_ready = grant & {N_SRC{take}};
endmodule

// File: rtl/trace_priv_agg_chk.sv
module trace_priv_agg_chk #(
   parameter int                 N_SRC     = 5,
   parameter int                 PAYLOAD_W = 32,
   parameter int                 DROP_W    = 8,
   parameter logic [2*N_SRC-1:0] SRC_TAGS  = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_SRC-1:0]     src_valid,
   input logic [N_SRC-1:0]     src_ready,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [PAYLOAD_W-1:0] out_data,
   input logic [1:0]           out_tag,
   input logic [1:0]           dbg_level,
   input logic [DROP_W-1:0]    drop_count
);
   function automatic logic tag_is_sourced(logic [1:0] t);
      logic hit;
      hit = 1'b0;
      for (int i = 0; i < N_SRC; i++) if (SRC_TAGS[2*i +: 2] == t) hit = 1'b1;
      return hit;
   endfunction

   // R3
   no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_tag <= dbg_level));

   // R2
   tag_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> tag_is_sourced(out_tag));

   // R6
   hold_intact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

   // R7
   level_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> $stable(dbg_level));

   // R4
   drop_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drop_count >= $past(drop_count)));

   // R8
   one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_ready));

   // R8
   take_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_ready & ~src_valid) == '0));
endmodule

bind trace_priv_agg trace_priv_agg_chk #(
   .N_SRC(N_SRC), .PAYLOAD_W(PAYLOAD_W), .DROP_W(DROP_W), .SRC_TAGS(SRC_TAGS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .out_tag(out_tag), .dbg_level(dbg_level), .drop_count(drop_count)
);

// File: tb/trace_priv_agg_tb.sv
module trace_priv_agg_tb;
   localparam int N   = 5;
   localparam int W   = 16;
   localparam int DW  = 4;
   localparam logic [2*N-1:0] TAGS = 10'b00_00_01_10_11;
   localparam int DMAX = (1 << DW) - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic [N-1:0]   src_valid, src_ready;
   logic [N*W-1:0] src_data;
   logic           auth_valid;
   logic [1:0]     auth_level;
   logic           out_valid, out_ready;
   logic [W-1:0]   out_data;
   logic [1:0]     out_tag, dbg_level;
   logic [DW-1:0]  drop_count;

   always #2.5 clk = ~clk;

   trace_priv_agg #(.N_SRC(N), .PAYLOAD_W(W), .DROP_W(DW), .SRC_TAGS(TAGS)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
      .src_data(src_data), .auth_valid(auth_valid), .auth_level(auth_level),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_tag(out_tag), .dbg_level(dbg_level), .drop_count(drop_count));

   int checks = 0, fails = 0;
   bit done = 0;

   // stimulus knobs
   int p_new = 40, p_rdy = 100, p_auth = 0, force_auth = -1;
   logic [N-1:0] src_mask = '1;

   // source side
   logic [N-1:0] pend = '0;
   logic [W-1:0] pdata [N];
   logic [7:0]   seq [N];

   // reference model
   logic [W+1:0] expq [$];
   logic [1:0]   m_lvl = 0, m_plvl = 0;
   bit           m_pend = 0;
   int           m_drop = 0, lastg = N - 1;
   bit           prev_stall = 0;
   logic [W+1:0] prev_rec;

   function automatic logic [1:0] tag_of(int i);
      return TAGS[2*i +: 2];
   endfunction

   function automatic int rr_pick(logic [N-1:0] v, int last);
      for (int k = 1; k <= N; k++) if (v[(last + k) % N]) return (last + k) % N;
      return -1;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic eval();
      logic [1:0] lnew;
      bit bnd, ap;
      int pick, taken, ntaken;
      // state after the previous edge
      chk(dbg_level == m_lvl, "R9", 32'(dbg_level), 32'(m_lvl));
      chk(drop_count == DW'(m_drop), "R4", 32'(drop_count), 32'(m_drop));
      if (prev_stall) chk(out_valid && {out_tag, out_data} == prev_rec, "R6",
                          32'({out_tag, out_data}), 32'(prev_rec));
      if (out_valid) chk(out_tag <= m_lvl, "R3", 32'(out_tag), 32'(m_lvl));
      bnd = !out_valid || out_ready;
      if (out_valid && out_ready) begin
         if (expq.size() == 0) chk(0, "R2", 32'({out_tag, out_data}), 32'hdead);
         else begin
            chk({out_tag, out_data} == expq[0], "R2", 32'({out_tag, out_data}), 32'(expq[0]));
            void'(expq.pop_front());
         end
      end
      prev_stall = out_valid && !out_ready;
      prev_rec   = {out_tag, out_data};
      ap   = bnd && (auth_valid || m_pend);
      lnew = ap ? (auth_valid ? auth_level : m_plvl) : m_lvl;
      if (ap) m_pend = 0;
      else if (auth_valid) begin m_pend = 1; m_plvl = auth_level; end
      pick = bnd ? rr_pick(src_valid, lastg) : -1;
      chk(pick < 0 ? src_ready == '0 : src_ready == N'(1 << pick), "R5",
          32'(src_ready), pick < 0 ? 0 : 32'(1 << pick));
      ntaken = 0; taken = -1;
      for (int i = 0; i < N; i++) if (src_valid[i] && src_ready[i]) begin ntaken++; taken = i; end
      chk(ntaken <= 1 && (bnd || ntaken == 0), "R8", 32'(ntaken), 32'(bnd));
      if (taken >= 0) begin
         if (tag_of(taken) <= lnew) expq.push_back({tag_of(taken), pdata[taken]});
         else if (m_drop < DMAX) m_drop++;
         lastg = taken;
         pend[taken] = 0;
      end
      m_lvl = lnew;
   endtask

   task automatic cycle();
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         if (!pend[i] && src_mask[i] && ($urandom % 100) < p_new) begin
            pend[i] = 1; seq[i]++;
            pdata[i] = {8'(i), seq[i]};
         end
         src_data[i*W +: W] = pdata[i];
      end
      src_valid = pend;
      out_ready = ($urandom % 100) < p_rdy;
      if (force_auth >= 0) begin
         auth_valid = 1; auth_level = 2'(force_auth); force_auth = -1;
      end else begin
         auth_valid = ($urandom % 100) < p_auth;
         auth_level = 2'($urandom);
      end
      #1 eval();
   endtask

   initial begin
      void'($urandom(32'h5eed_71ac));
      rst_n = 0; src_valid = '0; src_data = '0; auth_valid = 0; auth_level = 0; out_ready = 0;
      for (int i = 0; i < N; i++) begin pdata[i] = '0; seq[i] = '0; end
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(out_valid == 0, "R1", 32'(out_valid), 0);
      chk(dbg_level == 0, "R1", 32'(dbg_level), 0);
      chk(drop_count == 0, "R1", 32'(drop_count), 0);
      @(negedge clk) rst_n = 1;
      // public debugger, only the design-house source offers: all discarded, counter saturates (R4)
      src_mask = 5'b00001; p_new = 100; p_rdy = 100;
      repeat (40) cycle();
      chk(drop_count == DW'(DMAX), "R4", 32'(drop_count), DMAX);
      chk(!out_valid, "R3", 32'(out_valid), 0);
      // raise clearance, all sources, mixed backpressure (R5, R2)
      force_auth = 3; src_mask = '1; p_new = 40; p_rdy = 50;
      repeat (600) cycle();
      // stall with a record held, lower clearance during the stall (R7)
      p_rdy = 0;
      while (!out_valid) cycle();
      force_auth = 0;
      repeat (6) cycle();
      chk(dbg_level == 2'd3, "R7", 32'(dbg_level), 3);
      p_rdy = 100;
      repeat (3) cycle();
      chk(dbg_level == 2'd0, "R7", 32'(dbg_level), 0);
      // random clearance strobes on all kinds of cycles
      p_auth = 8;
      for (int ph = 0; ph < 4; ph++) begin
         p_rdy = 25 + 25 * ph; p_new = 20 + 20 * ph;
         repeat (800) cycle();
      end
      // drain
      p_auth = 0; src_mask = '0; p_rdy = 100;
      repeat (30) cycle();
      chk(expq.size() == 0, "R2", 32'(expq.size()), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule